// File: doc/BRIEF.md
# Wrapping Program Counter with Fixed Vectors

This block holds the instruction address of a small microcontroller core that fetches 14-bit instruction words. The architectural counter is 13 bits wide, which names an 8K-word program space, but only the lowest 2K words exist as physical memory. The block drives the fetch address into that memory as the low 11 bits of the counter. Any address above the implemented region therefore lands back inside the first 2K words, and no compare or subtract logic is needed for it.

Each cycle the counter takes one of five actions. In priority order these are a synchronous reset to the reset vector, interrupt entry to the interrupt vector, a load from the jump or return path, a sequential increment, or holding its value. When an interrupt is accepted, the block presents the address of the next sequential instruction on a return-address output for one cycle, so that an external stack can save it. The return stack, instruction decode, interrupt enabling and the memory itself sit outside this block.

Top module: `prog_ctr`

## Requirements
- R1: While rst_ni is low, pc_o is 0000h, fetch_addr_o is 000h and ret_valid_o is 0.
- R2: If sync_rst_i is high at a rising edge, pc_o becomes 0000h after that edge, whatever the other inputs are. ret_valid_o is 0 after that edge.
- R3: If irq_ack_i is high and sync_rst_i is low at a rising edge, pc_o becomes 0004h after that edge, whatever load_en_i and inc_en_i are.
- R4: For exactly the one cycle after an edge that accepts an interrupt as in R3, ret_valid_o is 1 and ret_addr_o equals (pc_o before the edge + 1) mod 8192. In every other cycle ret_valid_o is 0.
- R5: If load_en_i is high at an edge and neither sync_rst_i nor irq_ack_i is high, pc_o becomes load_addr_i after that edge, whatever inc_en_i is.
- R6: If only inc_en_i is high at an edge, pc_o becomes (pc_o + 1) mod 8192, so 1FFFh steps to 0000h.
- R7: With none of sync_rst_i, irq_ack_i, load_en_i or inc_en_i high, pc_o keeps its value.
- R8: fetch_addr_o always equals pc_o mod 2048. An increment from 07FFh gives pc_o 0800h and fetch_addr_o 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous reset to vector 0000h |
| irq_ack_i | input | 1 | Interrupt accept pulse |
| load_en_i | input | 1 | Load strobe for a jump or return |
| load_addr_i | input | 13 | Value to load |
| inc_en_i | input | 1 | Sequential increment enable |
| pc_o | output | 13 | Architectural counter value |
| fetch_addr_o | output | 11 | Physical fetch address into 2K memory |
| ret_valid_o | output | 1 | Return address valid, one cycle after interrupt accept |
| ret_addr_o | output | 13 | Address of the next sequential instruction |

## Verification
A wrong counter state shows on pc_o and on fetch_addr_o in the cycle right after the edge that caused it. The bench therefore compares both outputs after every edge. It loads every one of the 8192 addresses, increments from each of them, and so covers every wrap, including 07FFh to 0800h and 1FFFh to 0000h. A bad priority decision or a stale return capture shows on ret_valid_o or ret_addr_o after one edge, so it cannot hide behind later cycles.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned PC_W_DEF   = 13;
  localparam int unsigned PHYS_W_DEF = 11;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_RST,
    SEL_IRQ,
    SEL_LOAD,
    SEL_INC
  } pc_sel_e;
endpackage

// File: rtl/prog_ctr_next.sv
module prog_ctr_next import pc_pkg::*; #(
  parameter int unsigned PC_W = PC_W_DEF,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
  input  logic            sync_rst_i,
  input  logic            irq_ack_i,
  input  logic            load_en_i,
  input  logic [PC_W-1:0] load_addr_i,
  input  logic            inc_en_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_nxt_o,
  output logic [PC_W-1:0] pc_inc_o,
  output pc_sel_e         sel_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  assign pc_inc_o = pc_i + ONE;  // modulo 2^PC_W

  always_comb begin
    if (sync_rst_i)     sel_o = SEL_RST;
    else if (irq_ack_i) sel_o = SEL_IRQ;
    else if (load_en_i) sel_o = SEL_LOAD;
    else if (inc_en_i)  sel_o = SEL_INC;
    else                sel_o = SEL_HOLD;
  end

  always_comb begin
    unique case (sel_o)
      SEL_RST:  pc_nxt_o = RST_VEC;
      SEL_IRQ:  pc_nxt_o = INT_VEC;
      SEL_LOAD: pc_nxt_o = load_addr_i;
      SEL_INC:  pc_nxt_o = pc_inc_o;
      default:  pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/prog_ctr_reg.sv
module prog_ctr_reg import pc_pkg::*; #(
  parameter int unsigned PC_W = PC_W_DEF,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_rst_i,
  input  logic            irq_ack_i,
  input  logic            load_en_i,
  input  logic [PC_W-1:0] load_addr_i,
  input  logic            inc_en_i,
  input  logic [PC_W-1:0] pc_nxt_i,
  input  logic [PC_W-1:0] pc_inc_i,
  input  pc_sel_e         sel_i,
  output logic [PC_W-1:0] pc_o,
  output logic            ret_valid_o,
  output logic [PC_W-1:0] ret_addr_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= RST_VEC;
    else         pc_o <= pc_nxt_i;
  end

  // return address captured only on an accepted interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_valid_o <= 1'b0;
      ret_addr_o  <= '0;
    end else begin
      ret_valid_o <= (sel_i == SEL_IRQ);
      if (sel_i == SEL_IRQ) ret_addr_o <= pc_inc_i;
    end
  end

  p_sync_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (pc_o == RST_VEC) && !ret_valid_o);

  p_irq_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !sync_rst_i) |=> pc_o == INT_VEC);

  p_ret_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !sync_rst_i) |=> ret_valid_o && (ret_addr_o == $past(pc_o) + ONE));

  p_ret_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_ack_i && !sync_rst_i) |=> !ret_valid_o);

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && !irq_ack_i && !sync_rst_i) |=> pc_o == $past(load_addr_i));

  p_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_en_i && !load_en_i && !irq_ack_i && !sync_rst_i) |=> pc_o == $past(pc_o) + ONE);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_en_i || load_en_i || irq_ack_i || sync_rst_i) |=> $stable(pc_o));
endmodule

// File: rtl/prog_ctr_fold.sv
module prog_ctr_fold #(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned PHYS_W = 11
) (
  input  logic [PC_W-1:0]   pc_i,
  output logic [PHYS_W-1:0] fetch_addr_o
);
  generate
    if (PHYS_W >= PC_W) begin : g_full
      assign fetch_addr_o = PHYS_W'(pc_i);
    end else begin : g_wrap
      // upper bits dropped: addresses above the physical region alias onto it
      assign fetch_addr_o = pc_i[PHYS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/prog_ctr.sv
module prog_ctr import pc_pkg::*; #(
  parameter int unsigned PC_W   = PC_W_DEF,
  parameter int unsigned PHYS_W = PHYS_W_DEF,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_rst_i,
  input  logic              irq_ack_i,
  input  logic              load_en_i,
  input  logic [PC_W-1:0]   load_addr_i,
  input  logic              inc_en_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PHYS_W-1:0] fetch_addr_o,
  output logic              ret_valid_o,
  output logic [PC_W-1:0]   ret_addr_o
);
  logic [PC_W-1:0] pc_nxt, pc_inc;
  pc_sel_e         sel;

  prog_ctr_next #(.PC_W(PC_W), .RST_VEC(RST_VEC), .INT_VEC(INT_VEC)) u_next (
    .sync_rst_i (sync_rst_i),
    .irq_ack_i  (irq_ack_i),
    .load_en_i  (load_en_i),
    .load_addr_i(load_addr_i),
    .inc_en_i   (inc_en_i),
    .pc_i       (pc_o),
    .pc_nxt_o   (pc_nxt),
    .pc_inc_o   (pc_inc),
    .sel_o      (sel)
  );

  prog_ctr_reg #(.PC_W(PC_W), .RST_VEC(RST_VEC), .INT_VEC(INT_VEC)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_rst_i (sync_rst_i),
    .irq_ack_i  (irq_ack_i),
    .load_en_i  (load_en_i),
    .load_addr_i(load_addr_i),
    .inc_en_i   (inc_en_i),
    .pc_nxt_i   (pc_nxt),
    .pc_inc_i   (pc_inc),
    .sel_i      (sel),
    .pc_o       (pc_o),
    .ret_valid_o(ret_valid_o),
    .ret_addr_o (ret_addr_o)
  );

  prog_ctr_fold #(.PC_W(PC_W), .PHYS_W(PHYS_W)) u_fold (
    .pc_i        (pc_o),
    .fetch_addr_o(fetch_addr_o)
  );

  p_fold_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_en_i && !load_en_i && !irq_ack_i && !sync_rst_i && (&fetch_addr_o))
      |=> fetch_addr_o == '0);
endmodule

// File: tb/sim_prog_ctr.sv
`timescale 1ns/1ps
module sim_prog_ctr;
  logic        clk = 0, rst_ni = 0;
  logic        sync_rst, irq, ld, inc;
  logic [12:0] ld_addr;
  logic [12:0] pc, ret_addr;
  logic [10:0] fa;
  logic        ret_v;
  int errors = 0, checks = 0;
  bit  done = 0;

  always #4 clk = ~clk;  // 125 MHz

  prog_ctr u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sync_rst_i(sync_rst), .irq_ack_i(irq),
    .load_en_i(ld), .load_addr_i(ld_addr), .inc_en_i(inc),
    .pc_o(pc), .fetch_addr_o(fa), .ret_valid_o(ret_v), .ret_addr_o(ret_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs, take one edge, sample 2 ns later
  task automatic step(input logic s, input logic q, input logic l,
                      input logic [12:0] a, input logic n);
    sync_rst = s; irq = q; ld = l; ld_addr = a; inc = n;
    @(posedge clk); #2;
    sync_rst = 0; irq = 0; ld = 0; inc = 0;
  endtask

  task automatic chk_pc(input string req, input logic [12:0] exp);
    chk(req, {19'b0, pc}, {19'b0, exp});
    chk("R8", {21'b0, fa}, {21'b0, exp[10:0]});
  endtask

  initial begin
    sync_rst = 0; irq = 0; ld = 0; inc = 0; ld_addr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", {19'b0, pc}, 0);
    chk("R1", {21'b0, fa}, 0);
    chk("R1", {31'b0, ret_v}, 0);
    rst_ni = 1;
    @(posedge clk); #2;

    // sweep: load every address, then increment and hold
    for (int a = 0; a < 8192; a++) begin
      step(0, 0, 1, 13'(a), 1);
      chk_pc("R5", 13'(a));
      step(0, 0, 0, 13'h0, 1);
      chk_pc("R6", 13'((a + 1) % 8192));
      chk("R4", {31'b0, ret_v}, 0);
    end

    // wrap corners
    step(0, 0, 1, 13'h07FF, 0);
    step(0, 0, 0, 0, 1);
    chk("R8", {19'b0, pc}, 13'h0800);
    chk("R8", {21'b0, fa}, 0);
    step(0, 0, 1, 13'h1FFF, 0);
    step(0, 0, 0, 0, 1);
    chk_pc("R6", 0);

    // hold
    step(0, 0, 1, 13'h1234, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, 0);
      chk_pc("R7", 13'h1234);
    end

    // interrupt from several addresses, beating load and inc
    for (int k = 0; k < 8192; k += 509) begin
      step(0, 0, 1, 13'(k), 0);
      step(0, 1, (k % 2) == 1, 13'h0AAA, 1);
      chk_pc("R3", 13'h0004);
      chk("R4", {31'b0, ret_v}, 1);
      chk("R4", {19'b0, ret_addr}, 32'((k + 1) % 8192));
      step(0, 0, 0, 0, 0);
      chk("R4", {31'b0, ret_v}, 0);
    end
    step(0, 0, 1, 13'h1FFF, 0);
    step(0, 1, 0, 0, 0);
    chk("R4", {19'b0, ret_addr}, 0);

    // synchronous reset beats everything
    step(0, 0, 1, 13'h0777, 0);
    step(1, 1, 1, 13'h0555, 1);
    chk_pc("R2", 0);
    chk("R2", {31'b0, ret_v}, 0);
    step(0, 0, 1, 13'h1500, 0);
    step(1, 0, 0, 0, 0);
    chk_pc("R2", 0);

    // asynchronous reset mid-run
    step(0, 0, 1, 13'h0ABC, 0);
    step(0, 1, 0, 0, 0);
    #1 rst_ni = 0; #1;
    chk("R1", {19'b0, pc}, 0);
    chk("R1", {31'b0, ret_v}, 0);
    done = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done || errors > 0 && checks == 0);
    fork
      wait (done);
      begin repeat (100001) @(posedge clk); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule